// File: doc/BRIEF.md
# Interrupt Credit Auto-Mask Controller

This block moderates the interrupt of one descriptor ring. It keeps a count of descriptors that the device has finished but the driver has not yet acknowledged, which is the ring's credit count. On each cycle it decides whether the ring should ask for an MSI-X message. Each descriptor completion adds one credit. The driver gives credits back with a write that carries a count, and that count is subtracted.

An internal auto-mask bit controls when the block fires. When the ring is idle and unmasked, the first completion requests an interrupt and sets the auto-mask. While the ring is masked, further completions only add credits. A credit return that brings the count to zero clears the mask without firing. A credit return that leaves credits outstanding keeps the mask set and fires again, which tells the driver that work is still waiting. This bit is separate from the per-vector mask in the MSI-X table, where bit 0 set means masked. The block does not build the message and does not arbitrate between vectors.

The ring type and port number are parameters. From them the block derives a fixed vector number:
- command ring: vector 0
- event ring: vector 1
- test completion: vector 2
- vector 3 is left unused
- transmit ring of port p: vector 4+2p
- receive ring of port p: vector 5+2p

Top module: `irq_credit_ctl`

## Requirements
- R1: After reset the credit count is 0, the auto-mask is clear, and both the interrupt request and the error flag are low.
- R2: A completion while the ring is unmasked raises `irq_o` for exactly the one cycle after the completion cycle. It also sets the auto-mask and adds one credit.
- R3: A completion while the ring is masked adds one credit and does not raise `irq_o`.
- R4: A credit return that leaves the count at zero clears the auto-mask and does not raise `irq_o`. The auto-mask is never clear while credits are outstanding.
- R5: A credit return that leaves a nonzero count subtracts the returned amount, keeps the auto-mask set and raises `irq_o` for one cycle.
- R6: A credit return larger than the outstanding count sets the count to 0 and pulses `ret_err_o` for one cycle. It clears the auto-mask and does not raise `irq_o`.
- R7: `irq_vec_o` is constant and follows the parameters:
  - command ring: 0
  - event ring: 1
  - test completion: 2
  - transmit ring of port p: 4+2p
  - receive ring of port p: 5+2p
- R8: When a return and a completion arrive in the same cycle, the return is applied first. If the return empties the ring, the completion then fires from the unmasked state, leaving a count of 1 and the auto-mask set.
- R9: The credit count saturates at 2^CNT_W-1. It never wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_i | input | 1 | One descriptor completed this cycle |
| ret_wr_i | input | 1 | Credit-return write strobe |
| ret_cnt_i | input | CNT_W | Number of credits returned |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | VEC_W | Vector number of this ring |
| automask_o | output | 1 | Auto-mask state |
| credits_o | output | CNT_W | Outstanding credit count |
| ret_err_o | output | 1 | One-cycle pulse when a return exceeded the count |

## Verification
The main instance is built as the receive ring of port 5 with a 3-bit credit count. The narrow counter makes saturation at 7 reachable in a few completions, and it makes an over-return reachable with small values. Two further instances are built purely for the vector mapping, with the inputs tied off:
- the transmit ring of the highest port, 61, which gives the largest transmit vector, 126;
- the event ring, which gives a fixed low vector.

// File: rtl/icm_pkg.sv
package icm_pkg;
   typedef enum logic [2:0] {
      RK_CMD  = 3'd0,
      RK_EVT  = 3'd1,
      RK_TEST = 3'd2,
      RK_TX   = 3'd3,
      RK_RX   = 3'd4
   } ring_kind_e;

   localparam int FIXED_VEC_CMD  = 0;
   localparam int FIXED_VEC_EVT  = 1;
   localparam int FIXED_VEC_TEST = 2;
   localparam int PORT_VEC_BASE  = 4;
endpackage

// File: rtl/icm_vec_map.sv
module icm_vec_map #(
   parameter icm_pkg::ring_kind_e RING_KIND = icm_pkg::RK_CMD,
   parameter int PORT      = 0,
   parameter int NUM_PORTS = 62,
   parameter int VEC_W     = 8
) (
   output logic [VEC_W-1:0] vec_o
);
   localparam int TOP_VEC = icm_pkg::PORT_VEC_BASE + 2*NUM_PORTS - 1;

   if (TOP_VEC >= (1 << VEC_W)) begin : g_bad_width
      $error("VEC_W too narrow for NUM_PORTS");
   end
   if (PORT < 0 || PORT >= NUM_PORTS) begin : g_bad_port
      $error("PORT out of range");
   end

   if (RING_KIND == icm_pkg::RK_TX) begin : g_tx
      // even vectors for transmit
      assign vec_o = VEC_W'(icm_pkg::PORT_VEC_BASE + 2*PORT);
   end else if (RING_KIND == icm_pkg::RK_RX) begin : g_rx
      // odd vectors for receive
      assign vec_o = VEC_W'(icm_pkg::PORT_VEC_BASE + 2*PORT + 1);
   end else if (RING_KIND == icm_pkg::RK_EVT) begin : g_evt
      assign vec_o = VEC_W'(icm_pkg::FIXED_VEC_EVT);
   end else if (RING_KIND == icm_pkg::RK_TEST) begin : g_test
      assign vec_o = VEC_W'(icm_pkg::FIXED_VEC_TEST);
   end else begin : g_cmd
      assign vec_o = VEC_W'(icm_pkg::FIXED_VEC_CMD);
   end
endmodule

// File: rtl/icm_credit_ctr.sv
module icm_credit_ctr #(
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmpl_i,
   input  logic             ret_wr_i,
   input  logic [CNT_W-1:0] ret_cnt_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ret_zero_o,
   output logic             ret_over_o,
   output logic             err_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q, after_ret, cnt_d;
   logic             err_q;

   always_comb begin
      ret_over_o = ret_wr_i && (ret_cnt_i > cnt_q);
      if (!ret_wr_i)       after_ret = cnt_q;
      else if (ret_over_o) after_ret = '0;
      else                 after_ret = cnt_q - ret_cnt_i;
      ret_zero_o = ret_wr_i && (after_ret == '0);
      if (cmpl_i && after_ret != CNT_MAX) cnt_d = after_ret + 1'b1;
      else                                cnt_d = after_ret;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         err_q <= ret_over_o;
      end
   end

   assign cnt_o = cnt_q;
   assign err_o = err_q;

   assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && cmpl_i && !ret_wr_i) |=> (cnt_q == CNT_MAX));
   assert_over_clamps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_wr_i && ret_cnt_i > cnt_q && !cmpl_i) |=> (cnt_q == '0 && err_q));
endmodule

// File: rtl/icm_mask_fsm.sv
module icm_mask_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic cmpl_i,
   input  logic ret_wr_i,
   input  logic ret_zero_i,
   output logic masked_o,
   output logic irq_o
);
   logic masked_q, irq_q;
   logic eff_masked, fire_cmpl, fire_part, fire;

   always_comb begin
      // a return that empties the ring unmasks before a same-cycle completion
      eff_masked = masked_q && !(ret_wr_i && ret_zero_i);
      fire_cmpl  = cmpl_i && !eff_masked;
      fire_part  = masked_q && ret_wr_i && !ret_zero_i;
      fire       = fire_cmpl || fire_part;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         masked_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         masked_q <= fire ? 1'b1 : eff_masked;
         irq_q    <= fire;
      end
   end

   assign masked_o = masked_q;
   assign irq_o    = irq_q;

   assert_irq_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> masked_q);
   assert_masked_cmpl_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_q && cmpl_i && !ret_wr_i) |=> !irq_q);
endmodule

// File: rtl/irq_credit_ctl.sv
module irq_credit_ctl #(
   parameter int CNT_W     = 17,
   parameter int VEC_W     = 8,
   parameter int NUM_PORTS = 62,
   parameter icm_pkg::ring_kind_e RING_KIND = icm_pkg::RK_CMD,
   parameter int PORT      = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmpl_i,
   input  logic             ret_wr_i,
   input  logic [CNT_W-1:0] ret_cnt_i,
   output logic             irq_o,
   output logic [VEC_W-1:0] irq_vec_o,
   output logic             automask_o,
   output logic [CNT_W-1:0] credits_o,
   output logic             ret_err_o
);
   logic ret_zero, ret_over;

   icm_credit_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i), .ret_wr_i(ret_wr_i),
      .ret_cnt_i(ret_cnt_i), .cnt_o(credits_o), .ret_zero_o(ret_zero),
      .ret_over_o(ret_over), .err_o(ret_err_o)
   );

   icm_mask_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i), .ret_wr_i(ret_wr_i),
      .ret_zero_i(ret_zero), .masked_o(automask_o), .irq_o(irq_o)
   );

   icm_vec_map #(.RING_KIND(RING_KIND), .PORT(PORT), .NUM_PORTS(NUM_PORTS),
                 .VEC_W(VEC_W)) u_vec (.vec_o(irq_vec_o));

   assert_unmasked_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !automask_o |-> (credits_o == '0));
   assert_err_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_over && !cmpl_i) |=> (!irq_o && !automask_o));
   assert_vec_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(irq_vec_o));
endmodule

// File: tb/sim_irq_credit_ctl.sv
module sim_irq_credit_ctl;
   localparam int CW = 3;
   localparam int VW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmpl = 1'b0, ret_wr = 1'b0;
   logic [CW-1:0] ret_cnt = '0;
   logic irq, amask, err;
   logic [VW-1:0] vec0, vec1, vec2;
   logic [CW-1:0] cred;
   logic irq1, am1, er1, irq2, am2, er2;
   logic [CW-1:0] cr1, cr2;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_credit_ctl #(.CNT_W(CW), .VEC_W(VW), .RING_KIND(icm_pkg::RK_RX), .PORT(5)) u0 (
      .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl), .ret_wr_i(ret_wr), .ret_cnt_i(ret_cnt),
      .irq_o(irq), .irq_vec_o(vec0), .automask_o(amask), .credits_o(cred), .ret_err_o(err));
   irq_credit_ctl #(.CNT_W(CW), .VEC_W(VW), .RING_KIND(icm_pkg::RK_TX), .PORT(61)) u1 (
      .clk(clk), .rst_n(rst_n), .cmpl_i(1'b0), .ret_wr_i(1'b0), .ret_cnt_i('0),
      .irq_o(irq1), .irq_vec_o(vec1), .automask_o(am1), .credits_o(cr1), .ret_err_o(er1));
   irq_credit_ctl #(.CNT_W(CW), .VEC_W(VW), .RING_KIND(icm_pkg::RK_EVT), .PORT(0)) u2 (
      .clk(clk), .rst_n(rst_n), .cmpl_i(1'b0), .ret_wr_i(1'b0), .ret_cnt_i('0),
      .irq_o(irq2), .irq_vec_o(vec2), .automask_o(am2), .credits_o(cr2), .ret_err_o(er2));

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   // apply one cycle of stimulus, sample just after the edge that registers it
   task automatic step(input logic c, input logic w, input int n);
      @(negedge clk);
      cmpl = c; ret_wr = w; ret_cnt = CW'(n);
      @(posedge clk); #1;
      @(negedge clk);
      cmpl = 1'b0; ret_wr = 1'b0; ret_cnt = '0;
   endtask

   task automatic expect_state(input string req, input int i, input int m, input int c, input int e);
      chk({req, " irq"}, int'(irq), i);
      chk({req, " automask"}, int'(amask), m);
      chk({req, " credits"}, int'(cred), c);
      chk({req, " err"}, int'(err), e);
   endtask

   task automatic t_reset;
      expect_state("R1 reset", 0, 0, 0, 0);
      chk("R7 rx port5 vec", int'(vec0), 15);
      chk("R7 tx port61 vec", int'(vec1), 126);
      chk("R7 event vec", int'(vec2), 1);
   endtask

   task automatic t_first_fire;
      step(1, 0, 0);
      expect_state("R2 first completion", 1, 1, 1, 0);
      @(posedge clk); #1;
      chk("R2 single pulse", int'(irq), 0);
   endtask

   task automatic t_masked_cmpl;
      step(1, 0, 0);
      chk("R3 masked cmpl irq", int'(irq), 0);
      step(1, 0, 0);
      expect_state("R3 masked cmpl", 0, 1, 3, 0);
   endtask

   task automatic t_partial;
      step(0, 1, 2);
      expect_state("R5 partial return", 1, 1, 1, 0);
      @(posedge clk); #1;
      chk("R5 pulse ends", int'(irq), 0);
   endtask

   task automatic t_full;
      step(0, 1, 1);
      expect_state("R4 full return", 0, 0, 0, 0);
   endtask

   task automatic t_over;
      step(1, 0, 0);
      expect_state("R2 refire", 1, 1, 1, 0);
      step(0, 1, 3);
      expect_state("R6 over return", 0, 0, 0, 1);
      @(posedge clk); #1;
      chk("R6 err pulse ends", int'(err), 0);
   endtask

   task automatic t_same_cycle;
      step(1, 0, 0);
      step(1, 1, 1);
      expect_state("R8 return+cmpl", 1, 1, 1, 0);
      step(0, 1, 1);
      expect_state("R4 cleanup", 0, 0, 0, 0);
   endtask

   task automatic t_sat;
      step(1, 0, 0);
      for (int k = 0; k < 8; k++) step(1, 0, 0);
      expect_state("R9 saturate", 0, 1, 7, 0);
      step(0, 1, 7);
      expect_state("R4 drain", 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_first_fire();
      t_masked_cmpl();
      t_partial();
      t_full();
      t_over();
      t_same_cycle();
      t_sat();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog got 0 expected 1");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule